// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces a single analog-to-digital conversion on the system clock. Time is measured only on cycles where the ADC clock-enable strobe is high. A requester issues a start while the block is ready and supplies two command fields. The first is a 2-bit sample-time code. The second is a flag that marks a differential input rather than a single-ended one.

Once started, the block raises its sample output for the number of strobes the code selects. It then raises its convert output for a fixed count that depends on the input mode. After that it emits a one-cycle done pulse and becomes ready again. The time one conversion takes is the sample count plus the convert count. The conversion rate is therefore the ADC clock rate divided by that sum, and the 2-strobe sample setting gives the fastest rate.

A single down-counter is shared by both phases. It is reloaded at each phase boundary. The phase lengths are parameters, and their defaults fit a 12-bit converter.

Top module: `adc_conv_timer`

## Requirements
- R1: While reset is low and after it is released with no start, ready is 1 and sample, convert and done are 0.
- R2: The sample phase lasts exactly as many strobes as the latched code selects: code 2'b00 gives 2, 2'b01 gives 8, 2'b10 gives 64 and 2'b11 gives 128.
- R3: With the differential flag at 1 when a start is accepted, the convert phase lasts exactly 13 strobes.
- R4: With the differential flag at 0 when a start is accepted, the convert phase lasts exactly 14 strobes.
- R5: Sample goes high on the cycle after a start is accepted while ready is high. Convert follows sample with no idle cycle between them. The two phases are never high together, and ready stays low during both.
- R6: On a cycle with the strobe low, neither phase output changes on the following cycle.
- R7: A start while ready is low is ignored. Changes to the code or the flag after acceptance do not alter the running conversion.
- R8: Done is high for exactly one cycle, directly after the cycle that carries the last convert strobe. Ready is high and both phases are low in that same cycle.
- R9: A start presented in the done cycle is accepted, and sample rises on the next cycle.
- R10: A synchronous reset during a conversion returns the block to the idle state of R1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request, taken when ready_o is high |
| ready_o | output | 1 | Idle and able to accept a start |
| samp_code_i | input | 2 | Sample-time select code |
| diff_i | input | 1 | 1 selects a differential conversion, 0 a single-ended one |
| tick_i | input | 1 | ADC clock-enable strobe; counting happens only when it is high |
| sample_o | output | 1 | Sample phase active |
| convert_o | output | 1 | Convert phase active |
| done_o | output | 1 | One-cycle pulse at the end of a conversion |

## Verification
The bench builds the block with its default lengths of 2, 8, 64 and 128 sample strobes and 13 or 14 convert strobes. At these values every sample code and both input modes can be run in full, with strobe spacings of one to five cycles, in a few thousand cycles. The spacing shows whether the counts depend on strobes rather than clock cycles. Each phase is measured by counting the strobes that occur while it is high. The field changes made after acceptance, the starts sent while busy and the back-to-back start in the done cycle all fit within these default lengths.

// File: rtl/adc_seq_pkg.sv
// Package adc_seq_pkg
// Shared types and helper functions for the conversion timing sequencer.
// Assumes every phase length is at least 1.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_CONVERT = 2'd2
    } phase_t;

    // Returns the sample length chosen by a 2-bit code.
    function automatic int pick_len(input logic [1:0] code,
                                    input int l0, input int l1,
                                    input int l2, input int l3);
        case (code)
            2'd0:    return l0;
            2'd1:    return l1;
            2'd2:    return l2;
            default: return l3;
        endcase
    endfunction

    // Returns the larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_len_sel.sv
// Module adc_seq_len_sel
// Turns the sample code and the latched mode flag into phase lengths.
// The four sample lengths are built into a small table with a generate loop.
// Assumes CNT_W can hold every length.
module adc_seq_len_sel
    import adc_seq_pkg::*;
#(
    parameter int SAMP_T0     = 2,
    parameter int SAMP_T1     = 8,
    parameter int SAMP_T2     = 64,
    parameter int SAMP_T3     = 128,
    parameter int CONV_T_DIFF = 13,
    parameter int CONV_T_SE   = 14,
    parameter int CNT_W       = 8
) (
    input  logic [1:0]       code_i,
    input  logic             diff_i,
    output logic [CNT_W-1:0] samp_len_o,
    output logic [CNT_W-1:0] conv_len_o
);

    logic [CNT_W-1:0] samp_tbl [4];

    // Fill one table entry per code value.
    for (genvar gi = 0; gi < 4; gi++) begin : g_tbl
        localparam int LEN = pick_len(gi[1:0], SAMP_T0, SAMP_T1, SAMP_T2, SAMP_T3);
        assign samp_tbl[gi] = CNT_W'(LEN);
    end

    // Choose the sample length from the code.
    always_comb samp_len_o = samp_tbl[code_i];

    // Choose the convert length from the input mode.
    always_comb conv_len_o = diff_i ? CNT_W'(CONV_T_DIFF) : CNT_W'(CONV_T_SE);

endmodule

// File: rtl/adc_seq_tick_cnt.sv
// Module adc_seq_tick_cnt
// A loadable down-counter that steps only on strobe cycles. last_o flags
// the final strobe of a phase, when the count stands at 1.
// A load takes priority over counting. Loaded values are at least 1.
module adc_seq_tick_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load, or count down one on each strobe while the count is nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    // Mark the count at which the next strobe ends the phase.
    always_comb last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/adc_seq_fsm.sv
// Module adc_seq_fsm
// Phase controller with three states: idle, sample and convert. It takes a
// start only when idle and latches the mode flag at that moment. It reloads
// the shared counter at every phase boundary and pulses done on the way
// back to idle. Assumes the counter's last_o is valid in each busy state.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             diff_i,
    input  logic             tick_i,
    input  logic             last_i,
    input  logic [CNT_W-1:0] samp_len_i,
    input  logic [CNT_W-1:0] conv_len_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             diff_q_o,
    output logic             ready_o,
    output logic             sample_o,
    output logic             convert_o,
    output logic             done_o
);

    phase_t state_q;
    logic   done_q;
    logic   diff_q;
    logic   accept;
    logic   end_phase;

    // Detect an accepted start and the final strobe of a phase.
    always_comb begin
        accept    = (state_q == PH_IDLE) && start_i;
        end_phase = tick_i && last_i;
    end

    // Advance the phase, latch the mode flag and raise the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            done_q  <= 1'b0;
            diff_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                PH_IDLE: if (accept) begin
                    state_q <= PH_SAMPLE;
                    diff_q  <= diff_i;
                end
                PH_SAMPLE: if (end_phase)
                    state_q <= PH_CONVERT;
                PH_CONVERT: if (end_phase) begin
                    state_q <= PH_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    // Reload the counter on a start and at the sample-to-convert boundary.
    always_comb begin
        load_o     = accept || ((state_q == PH_SAMPLE) && end_phase);
        load_val_o = (state_q == PH_IDLE) ? samp_len_i : conv_len_i;
    end

    // Decode the state to the outputs.
    always_comb begin
        ready_o   = (state_q == PH_IDLE);
        sample_o  = (state_q == PH_SAMPLE);
        convert_o = (state_q == PH_CONVERT);
        done_o    = done_q;
        diff_q_o  = diff_q;
    end

endmodule

// File: rtl/adc_conv_timer.sv
// Module adc_conv_timer (top)
// Paces one conversion as a sample phase followed by a convert phase, with
// time counted in clock-enable strobes. Everything runs on clk. Assumes all
// length parameters are at least 1.
module adc_conv_timer
    import adc_seq_pkg::*;
#(
    parameter int SAMP_T0     = 2,
    parameter int SAMP_T1     = 8,
    parameter int SAMP_T2     = 64,
    parameter int SAMP_T3     = 128,
    parameter int CONV_T_DIFF = 13,
    parameter int CONV_T_SE   = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       ready_o,
    input  logic [1:0] samp_code_i,
    input  logic       diff_i,
    input  logic       tick_i,
    output logic       sample_o,
    output logic       convert_o,
    output logic       done_o
);

    localparam int LEN_MAX = imax(imax(imax(SAMP_T0, SAMP_T1), imax(SAMP_T2, SAMP_T3)),
                                  imax(CONV_T_DIFF, CONV_T_SE));
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic [CNT_W-1:0] samp_len;
    logic [CNT_W-1:0] conv_len;
    logic [CNT_W-1:0] load_val;
    logic             load;
    logic             last;
    logic             diff_q;

    // Length lookup from the live code and the latched mode flag.
    adc_seq_len_sel #(
        .SAMP_T0(SAMP_T0), .SAMP_T1(SAMP_T1), .SAMP_T2(SAMP_T2), .SAMP_T3(SAMP_T3),
        .CONV_T_DIFF(CONV_T_DIFF), .CONV_T_SE(CONV_T_SE), .CNT_W(CNT_W)
    ) u_len (
        .code_i     (samp_code_i),
        .diff_i     (diff_q),
        .samp_len_o (samp_len),
        .conv_len_o (conv_len)
    );

    // Strobe counter shared by both phases.
    adc_seq_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .tick_i     (tick_i),
        .last_o     (last)
    );

    // Phase controller.
    adc_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .diff_i     (diff_i),
        .tick_i     (tick_i),
        .last_i     (last),
        .samp_len_i (samp_len),
        .conv_len_i (conv_len),
        .load_o     (load),
        .load_val_o (load_val),
        .diff_q_o   (diff_q),
        .ready_o    (ready_o),
        .sample_o   (sample_o),
        .convert_o  (convert_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/adc_conv_timer_chk.sv
// Module adc_conv_timer_chk
// Property checker bound to adc_conv_timer. It keeps its own count of the
// strobes seen in each phase and the command latched at each start, and
// compares these against the required lengths.
module adc_conv_timer_chk
    import adc_seq_pkg::*;
#(
    parameter int SAMP_T0     = 2,
    parameter int SAMP_T1     = 8,
    parameter int SAMP_T2     = 64,
    parameter int SAMP_T3     = 128,
    parameter int CONV_T_DIFF = 13,
    parameter int CONV_T_SE   = 14
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       ready_o,
    input logic [1:0] samp_code_i,
    input logic       diff_i,
    input logic       tick_i,
    input logic       sample_o,
    input logic       convert_o,
    input logic       done_o
);

    logic [1:0] code_c;
    logic       diff_c;
    int         samp_seen;
    int         conv_seen;

    // Record the command and count the strobes in each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_c    <= 2'd0;
            diff_c    <= 1'b0;
            samp_seen <= 0;
            conv_seen <= 0;
        end else if (start_i && ready_o) begin
            code_c    <= samp_code_i;
            diff_c    <= diff_i;
            samp_seen <= 0;
            conv_seen <= 0;
        end else begin
            if (sample_o && tick_i)  samp_seen <= samp_seen + 1;
            if (convert_o && tick_i) conv_seen <= conv_seen + 1;
        end
    end

    p_phase_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && convert_o));

    p_start_to_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ready_o) |=> (sample_o && !ready_o));

    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ready_o) |=> ($stable(sample_o) && $stable(convert_o)));

    p_samp_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convert_o) |-> (samp_seen == pick_len(code_c, SAMP_T0, SAMP_T1, SAMP_T2, SAMP_T3)));

    // Covers R3 and R4: the convert count depends on the latched mode.
    p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (conv_seen == (diff_c ? CONV_T_DIFF : CONV_T_SE)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ready_o && !sample_o && !convert_o));

    p_conv_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convert_o) |-> done_o);

endmodule

bind adc_conv_timer adc_conv_timer_chk #(
    .SAMP_T0(SAMP_T0), .SAMP_T1(SAMP_T1), .SAMP_T2(SAMP_T2), .SAMP_T3(SAMP_T3),
    .CONV_T_DIFF(CONV_T_DIFF), .CONV_T_SE(CONV_T_SE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ready_o     (ready_o),
    .samp_code_i (samp_code_i),
    .diff_i      (diff_i),
    .tick_i      (tick_i),
    .sample_o    (sample_o),
    .convert_o   (convert_o),
    .done_o      (done_o)
);

// File: tb/sim_adc_conv_timer.sv
// Bench sim_adc_conv_timer
// Directed scenarios, one task each. Inputs are driven and outputs sampled
// at the falling edge of the clock.
module sim_adc_conv_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic       ready_o;
    logic [1:0] samp_code_i;
    logic       diff_i;
    logic       tick_i;
    logic       sample_o;
    logic       convert_o;
    logic       done_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_conv_timer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
        .samp_code_i(samp_code_i), .diff_i(diff_i), .tick_i(tick_i),
        .sample_o(sample_o), .convert_o(convert_o), .done_o(done_o)
    );

    // Record one check and report it when it fails.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int samp_exp(input logic [1:0] c);
        case (c)
            2'd0: return 2;
            2'd1: return 8;
            2'd2: return 64;
            default: return 128;
        endcase
    endfunction

    // R1: idle outputs while reset is held and after it is released.
    task automatic t_reset();
        rst_n = 1'b0; start_i = 1'b0; samp_code_i = 2'd0; diff_i = 1'b0; tick_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready_o && !sample_o && !convert_o && !done_o, "R1 in reset",
            {ready_o, sample_o, convert_o, done_o}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && !sample_o && !convert_o && !done_o, "R1 after release",
            {ready_o, sample_o, convert_o, done_o}, 4'b1000);
    endtask

    // Full conversion; strobe every div cycles; spam sends starts while busy (R7).
    // Must be called at a falling edge. Returns at the falling edge where done is seen.
    task automatic t_conv(input logic [1:0] code, input bit diff, input int div, input bit spam);
        int  st = 0;
        int  ct = 0;
        int  cyc = 0;
        bit  ps = 1'b1;
        bit  pc = 1'b0;
        bit  pt = 1'b0;
        bit  hold_ok = 1'b1;
        bit  gap_ok = 1'b1;
        bit  seen = 1'b0;
        samp_code_i = code; diff_i = diff; start_i = 1'b1; tick_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(sample_o && !convert_o && !ready_o, "R5 sample after start",
            {sample_o, convert_o, ready_o}, 3'b100);
        chk(!done_o, "R8 done single cycle", done_o, 0);
        samp_code_i = ~code; diff_i = ~diff;
        for (int i = 0; i < 4000 && !seen; i++) begin
            tick_i = ((cyc % div) == 0);
            cyc++;
            start_i = spam && (i < 6);
            if (tick_i && sample_o)  st++;
            if (tick_i && convert_o) ct++;
            pt = tick_i; ps = sample_o; pc = convert_o;
            @(negedge clk);
            if (done_o) seen = 1'b1;
            else begin
                if (!pt && ((sample_o != ps) || (convert_o != pc))) hold_ok = 1'b0;
                if ((!sample_o && !convert_o) || ready_o || (sample_o && convert_o)) gap_ok = 1'b0;
            end
        end
        start_i = 1'b0; tick_i = 1'b0;
        chk(seen, "R8 done reached", seen, 1);
        chk(st == samp_exp(code), "R2 sample strobes", st, samp_exp(code));
        if (diff) chk(ct == 13, "R3 convert strobes differential", ct, 13);
        else      chk(ct == 14, "R4 convert strobes single-ended", ct, 14);
        chk(pc && pt, "R8 done follows last convert strobe", {pc, pt}, 2'b11);
        chk(ready_o && !sample_o && !convert_o, "R8 ready with done",
            {ready_o, sample_o, convert_o}, 3'b100);
        chk(hold_ok, "R6 hold without strobe", hold_ok, 1);
        chk(gap_ok, "R5 continuous busy phases", gap_ok, 1);
    endtask

    // R7/R8: after done with no start, the block stays idle and done drops.
    task automatic t_idle(input string req);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk(ready_o && !sample_o && !convert_o && !done_o, req,
            {ready_o, sample_o, convert_o, done_o}, 4'b1000);
    endtask

    // R9: start in the done cycle is accepted.
    task automatic t_back_to_back();
        t_conv(2'd1, 1'b1, 1, 1'b0);
        chk(ready_o && done_o, "R9 ready in done cycle", {ready_o, done_o}, 2'b11);
        t_conv(2'd0, 1'b0, 1, 1'b0);
        t_idle("R9 idle after second run");
    endtask

    // R10: synchronous reset in the middle of a conversion.
    task automatic t_reset_mid();
        samp_code_i = 2'd3; diff_i = 1'b0; start_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(sample_o, "R10 busy before reset", sample_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ready_o && !sample_o && !convert_o && !done_o, "R10 idle after reset",
            {ready_o, sample_o, convert_o, done_o}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && !sample_o && !convert_o, "R10 stays idle",
            {ready_o, sample_o, convert_o}, 3'b100);
    endtask

    initial begin
        t_reset();
        t_conv(2'd0, 1'b1, 1, 1'b0);
        t_idle("R8 done dropped");
        t_conv(2'd1, 1'b0, 2, 1'b0);
        t_idle("R8 idle after run");
        t_conv(2'd2, 1'b1, 3, 1'b0);
        t_idle("R8 idle after run");
        t_conv(2'd3, 1'b0, 1, 1'b0);
        t_idle("R8 idle after run");
        t_conv(2'd0, 1'b0, 5, 1'b1);
        t_idle("R7 busy starts ignored");
        t_back_to_back();
        t_reset_mid();
        t_conv(2'd2, 1'b0, 1, 1'b0);
        t_idle("R8 idle after run");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired: actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule